// File: doc/BRIEF.md
# DRAM Cycle Decoder with Compressed Parallel Test Mode

This block is a clocked behavioural model of a four-bit-wide DRAM's control decoder and cell array. On every rising clock edge it samples three active-low strobes (row strobe, column strobe, write enable) and a shared row/column address bus. From the order in which the strobes fall, it sorts each row-strobe cycle into one of four kinds:

- a normal access,
- a refresh with only the row strobe,
- a refresh with the column strobe leading the row strobe,
- a test-entry cycle, where the column strobe and write enable both lead the row strobe.

After reset the array is locked. It accepts reads and writes only once it has counted a set number of refresh cycles. A test-entry cycle latches a test flag, and the flag stays set until either kind of refresh clears it. While the flag is set, the two top column address bits are ignored. Each DQ line then stands for a group of four cells, one cell for each value of those two bits. A test write copies every data bit into all four cells of its group. A test read returns one bit per DQ: high when the four cells agree, low when they differ. A test read also arrives one clock later than a normal read.

The model is used to check test-mode firmware and memory-controller sequencing without analog timing. Output high impedance and charge refresh are not modelled.

Top module: `dram_ptest_top`

## Requirements
- R1: After reset, test_mode, ready, rd_valid and dq_out are all zero, and every cell holds zero.
- R2: ready goes high after exactly INIT_REFRESH (default 8) refresh cycles, of either refresh kind, have been seen since reset. Once high, it stays high until reset.
- R3: While ready is low, access cycles are ignored: a write leaves the array unchanged, and a read leaves rd_valid and dq_out at zero.
- R4: A normal access takes the row address from the first sample with ras_n low and cas_n high. It takes the column address from the first later sample with cas_n low. The access is a write when we_n is low at that sample. During a write, rd_valid stays low.
- R5: A normal read shows the addressed 4-bit word on dq_out, with rd_valid high, from the rising edge that first samples cas_n low. Both outputs return to zero on the edge that samples ras_n or cas_n high.
- R6: A sample that first sees ras_n low while cas_n and we_n are already low sets test_mode. The flag stays set across any number of later access cycles.
- R7: A sample that first sees ras_n low while cas_n is low and we_n is high is a refresh. It counts toward R2 and clears test_mode.
- R8: A row-strobe cycle whose ras_n returns high before any cas_n-low sample is a refresh. It counts toward R2 and clears test_mode.
- R9: In test mode, a write ignores column bits [COL_W-1:COL_W-2]. Data bit k is stored in bit k of all four columns that share the row and the low column bits.
- R10: In test mode, a read returns dq_out bit k = 1 when bit k of the four grouped cells is all ones or all zeros, and 0 otherwise.
- R11: A test-mode read shows its data one rising edge later than a normal read. rd_valid is still low after the edge that first samples cas_n low.
- R12: A test-entry cycle does not count toward the refresh total of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at column strobe fall |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 4 | Write data, one bit per DQ |
| dq_out | output | 4 | Read data, or per-DQ pass/fail in test mode; zero when not valid |
| rd_valid | output | 1 | dq_out carries read data |
| test_mode | output | 1 | Parallel test mode is latched |
| ready | output | 1 | Initial refresh count satisfied |

## Verification
A normal read is due one rising edge after the first sample with cas_n low. A test-mode read is due two edges after that sample. Both outputs clear one edge after the strobes are released. Refresh classification, and the resulting changes to test_mode and ready, show up one edge after the deciding sample.

The bench changes strobes only on falling edges and reads outputs on falling edges. It reads once after the first edge, which catches a test read that arrives early. It reads again after the second edge, and once more after release. Refresh and mode results are read at the falling edge that follows the deciding sample.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;

    localparam int DQ_W  = 4;
    localparam int GRP_N = 4;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_ROW  = 2'd1,
        CYC_COL  = 2'd2,
        CYC_REFR = 2'd3
    } cyc_state_e;

endpackage

// File: rtl/dram_ptest_decode.sv
module dram_ptest_decode
    import dram_ptest_pkg::*;
#(
    parameter int ROW_W        = 2,
    parameter int COL_W        = 4,
    parameter int ADDR_W       = 4,
    parameter int INIT_REFRESH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic             acc_wr,
    output logic             acc_rd,
    output logic [ROW_W-1:0] acc_row,
    output logic [COL_W-1:0] acc_col,
    output logic             test_mode,
    output logic             ready
);

    localparam int CNT_W = $clog2(INIT_REFRESH + 1);

    typedef struct packed {
        cyc_state_e       st;
        logic [ROW_W-1:0] row;
        logic             test;
        logic [CNT_W-1:0] cnt;
    } dec_t;

    dec_t dec_d, dec_q;
    logic refresh_hit;
    logic ready_int;

    assign ready_int = (dec_q.cnt == CNT_W'(INIT_REFRESH));

    always_comb begin
        dec_d       = dec_q;
        acc_wr      = 1'b0;
        acc_rd      = 1'b0;
        refresh_hit = 1'b0;
        unique case (dec_q.st)
            CYC_IDLE: begin
                if (!ras_n) begin
                    if (!cas_n) begin
                        dec_d.st = CYC_REFR;
                        if (!we_n) begin
                            dec_d.test = 1'b1;
                        end else begin
                            dec_d.test  = 1'b0;
                            refresh_hit = 1'b1;
                        end
                    end else begin
                        dec_d.row = addr[ROW_W-1:0];
                        dec_d.st  = CYC_ROW;
                    end
                end
            end
            CYC_ROW: begin
                if (ras_n) begin
                    dec_d.st    = CYC_IDLE;
                    dec_d.test  = 1'b0;
                    refresh_hit = 1'b1;
                end else if (!cas_n) begin
                    dec_d.st = CYC_COL;
                    if (ready_int) begin
                        acc_wr = !we_n;
                        acc_rd = we_n;
                    end
                end
            end
            default: begin
                if (ras_n) begin
                    dec_d.st = CYC_IDLE;
                end
            end
        endcase
        if (refresh_hit && !ready_int) begin
            dec_d.cnt = dec_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '{st: CYC_IDLE, row: '0, test: 1'b0, cnt: '0};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign acc_row   = dec_q.row;
    assign acc_col   = addr[COL_W-1:0];
    assign test_mode = dec_q.test;
    assign ready     = ready_int;

    // R6: the flag rises only after a sample of the entry strobe pattern
    assert_test_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_q.test) |-> $past(dec_q.st == CYC_IDLE && !ras_n && !cas_n && !we_n));

    // R7 and R8: the flag falls only after one of the two refresh kinds
    assert_test_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dec_q.test) |-> $past((dec_q.st == CYC_IDLE && !ras_n && !cas_n && we_n)
                                    || (dec_q.st == CYC_ROW && ras_n)));

    assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_one_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_wr, acc_rd}));

endmodule

// File: rtl/dram_ptest_array.sv
module dram_ptest_array
    import dram_ptest_pkg::*;
#(
    parameter int ROW_W = 2,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             test,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [DQ_W-1:0]  din,
    output logic [DQ_W-1:0]  rd_data
);

    localparam int LOW_W = COL_W - 2;
    localparam int IDX_W = ROW_W + COL_W;
    localparam int CELLS = 1 << IDX_W;

    typedef struct packed {
        logic [CELLS-1:0][DQ_W-1:0] mem;
    } arr_t;

    arr_t arr_d, arr_q;
    logic [DQ_W-1:0] cmp;

    always_comb begin
        arr_d = arr_q;
        if (wr) begin
            if (test) begin
                for (int g = 0; g < GRP_N; g++) begin
                    arr_d.mem[{row, 2'(g), col[LOW_W-1:0]}] = din;
                end
            end else begin
                arr_d.mem[{row, col}] = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    for (genvar k = 0; k < DQ_W; k++) begin : g_cmp
        logic [GRP_N-1:0] grp_bits;
        always_comb begin
            for (int g = 0; g < GRP_N; g++) begin
                grp_bits[g] = arr_q.mem[{row, 2'(g), col[LOW_W-1:0]}][k];
            end
        end
        assign cmp[k] = (grp_bits == '0) || (grp_bits == '1);
    end

    assign rd_data = test ? cmp : arr_q.mem[{row, col}];

    // R9: right after a test write, all four cells of each group match
    assert_group_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && test) |=> (arr_q.mem[{$past(row), 2'd0, $past(col[LOW_W-1:0])}] == $past(din))
                       && (arr_q.mem[{$past(row), 2'd3, $past(col[LOW_W-1:0])}] == $past(din)));

endmodule

// File: rtl/dram_ptest_rdpipe.sv
module dram_ptest_rdpipe
    import dram_ptest_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_start,
    input  logic            test,
    input  logic            keep,
    input  logic [DQ_W-1:0] data,
    output logic [DQ_W-1:0] dout,
    output logic            valid
);

    typedef struct packed {
        logic            pend;
        logic [DQ_W-1:0] pend_data;
        logic [DQ_W-1:0] dout;
        logic            valid;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (rd_start) begin
            if (test) begin
                pipe_d.pend      = 1'b1;
                pipe_d.pend_data = data;
                pipe_d.dout      = '0;
                pipe_d.valid     = 1'b0;
            end else begin
                pipe_d.pend  = 1'b0;
                pipe_d.dout  = data;
                pipe_d.valid = 1'b1;
            end
        end else if (!keep) begin
            pipe_d = '0;
        end else if (pipe_q.pend) begin
            pipe_d.pend  = 1'b0;
            pipe_d.dout  = pipe_q.pend_data;
            pipe_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout  = pipe_q.dout;
    assign valid = pipe_q.valid;

    assert_test_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && test) |=> !valid);

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!keep && !rd_start) |=> (!valid && dout == '0));

endmodule

// File: rtl/dram_ptest_top.sv
module dram_ptest_top
    import dram_ptest_pkg::*;
#(
    parameter int ROW_W        = 2,
    parameter int COL_W        = 4,
    parameter int ADDR_W       = 4,
    parameter int INIT_REFRESH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic              rd_valid,
    output logic              test_mode,
    output logic              ready
);

    logic             acc_wr;
    logic             acc_rd;
    logic [ROW_W-1:0] acc_row;
    logic [COL_W-1:0] acc_col;
    logic [DQ_W-1:0]  rd_data;
    logic             keep;

    assign keep = !ras_n && !cas_n;

    dram_ptest_decode #(
        .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .INIT_REFRESH(INIT_REFRESH)
    ) i_decode (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_row(acc_row),
        .acc_col(acc_col), .test_mode(test_mode), .ready(ready)
    );

    dram_ptest_array #(
        .ROW_W(ROW_W), .COL_W(COL_W)
    ) i_array (
        .clk(clk), .rst_n(rst_n), .wr(acc_wr), .test(test_mode), .row(acc_row),
        .col(acc_col), .din(dq_in), .rd_data(rd_data)
    );

    dram_ptest_rdpipe i_rdpipe (
        .clk(clk), .rst_n(rst_n), .rd_start(acc_rd), .test(test_mode),
        .keep(keep), .data(rd_data), .dout(dq_out), .valid(rd_valid)
    );

    assert_no_early_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ready);

endmodule

// File: tb/test_dram_ptest_top.sv
module test_dram_ptest_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n  = 1'b1;
    logic [3:0] addr  = '0;
    logic [3:0] dq_in = '0;
    logic [3:0] dq_out;
    logic       rd_valid;
    logic       test_mode;
    logic       ready;

    int total = 0;
    int bad   = 0;
    logic [3:0] mdl [64];
    logic       in_test = 1'b0;

    dram_ptest_top i_dram_ptest_top (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .rd_valid(rd_valid),
        .test_mode(test_mode), .ready(ready)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] squeeze(input logic [1:0] row, input logic [3:0] col);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) begin
            logic [3:0] b;
            for (int g = 0; g < 4; g++) b[g] = mdl[{row, 2'(g), col[1:0]}][k];
            r[k] = (b == 4'h0) || (b == 4'hF);
        end
        return r;
    endfunction

    task automatic model_write(input logic [1:0] row, input logic [3:0] col, input logic [3:0] d);
        if (in_test) begin
            for (int g = 0; g < 4; g++) mdl[{row, 2'(g), col[1:0]}] = d;
        end else begin
            mdl[{row, col}] = d;
        end
    endtask

    task automatic access(input logic [1:0] row, input logic [3:0] col, input logic wr,
                          input logic [3:0] d, input logic rdy);
        logic [3:0] exp;
        logic       v1;
        logic       v2;
        logic [3:0] d1;
        logic [3:0] d2;
        exp = in_test ? squeeze(row, col) : mdl[{row, col}];
        @(negedge clk); ras_n = 1'b0; addr = {2'b00, row};
        @(negedge clk); addr = col; cas_n = 1'b0; we_n = !wr; dq_in = d;
        @(negedge clk); v1 = rd_valid; d1 = dq_out;
        @(negedge clk); v2 = rd_valid; d2 = dq_out;
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk("R5 release", {rd_valid, dq_out}, 5'h00);
        if (!rdy) begin
            chk("R3 locked read", {v1, d1, v2, d2}, 10'h000);
        end else if (wr) begin
            chk("R4 write no data", {v1, v2}, 2'b00);
            model_write(row, col, d);
        end else if (!in_test) begin
            chk("R5 normal read", {v1, d1}, {1'b1, exp});
            chk("R4 normal hold", {v2, d2}, {1'b1, exp});
        end else begin
            chk("R11 test early", v1, 1'b0);
            chk("R10 test read", {v2, d2}, {1'b1, exp});
        end
    endtask

    task automatic ras_only(input logic [1:0] row);
        @(negedge clk); ras_n = 1'b0; addr = {2'b00, row};
        @(negedge clk); ras_n = 1'b1;
        @(negedge clk);
        in_test = 1'b0;
    endtask

    task automatic cas_first(input logic we);
        @(negedge clk); cas_n = 1'b0; we_n = we;
        @(negedge clk); ras_n = 1'b0;
        @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        in_test = !we;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] col;
        logic [3:0] dat;
        logic [1:0] row;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) mdl[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", {test_mode, ready, rd_valid, dq_out}, 7'h00);

        // accesses before the refresh count is met
        access(2'd0, 4'd3, 1'b1, 4'h9, 1'b0);
        access(2'd0, 4'd3, 1'b0, 4'h0, 1'b0);

        for (int i = 0; i < 7; i++) begin
            if (i % 2 == 0) ras_only(2'(i)); else cas_first(1'b1);
        end
        chk("R2 seven refreshes", ready, 1'b0);
        cas_first(1'b0);
        chk("R6 entry", test_mode, 1'b1);
        chk("R12 entry not counted", ready, 1'b0);
        cas_first(1'b1);
        chk("R7 cbr exit", test_mode, 1'b0);
        chk("R2 eighth refresh", ready, 1'b1);
        access(2'd0, 4'd3, 1'b0, 4'h0, 1'b1); // R3: earlier write dropped, reads 0

        // directed group scenario on row 1, low column bits 01
        for (int g = 0; g < 4; g++) begin
            access(2'd1, {2'(g), 2'b01}, 1'b1, (g == 2) ? 4'hE : 4'hA, 1'b1);
        end
        cas_first(1'b0);
        access(2'd1, 4'b0001, 1'b0, 4'h0, 1'b1);
        chk("R10 corrupt dq2 low", squeeze(2'd1, 4'b0001), 4'hB);
        access(2'd2, 4'd5, 1'b0, 4'h0, 1'b1);
        chk("R6 still latched", test_mode, 1'b1);
        access(2'd1, 4'b1101, 1'b1, 4'h5, 1'b1); // R9: top column bits ignored
        access(2'd1, 4'b0001, 1'b0, 4'h0, 1'b1);
        ras_only(2'd3);
        chk("R8 ras-only exit", test_mode, 1'b0);
        for (int g = 0; g < 4; g++) begin
            access(2'd1, {2'(g), 2'b01}, 1'b0, 4'h0, 1'b1);
        end
        chk("R9 model fill", mdl[6'b011001], 4'h5);

        // constrained random mix
        for (int i = 0; i < 120; i++) begin
            row = 2'($urandom_range(0, 3));
            col = 4'($urandom_range(0, 15));
            dat = 4'($urandom_range(0, 15));
            case ($urandom_range(0, 7))
                0, 1, 2: access(row, col, 1'b1, dat, 1'b1);
                3, 4, 5: access(row, col, 1'b0, 4'h0, 1'b1);
                6: begin
                    if (in_test) begin
                        if ($urandom_range(0, 1) == 0) ras_only(row); else cas_first(1'b1);
                        chk("R8 random exit", test_mode, 1'b0);
                    end else begin
                        cas_first(1'b0);
                        chk("R6 random entry", test_mode, 1'b1);
                    end
                end
                default: begin
                    access(row, col, 1'b1, dat, 1'b1);
                    if (in_test) chk("R9 group equal", squeeze(row, col), 4'hF);
                    access(row, col, 1'b0, 4'h0, 1'b1);
                end
            endcase
        end
        chk("R2 ready kept", ready, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule